// File: doc/BRIEF.md
# Transmit Frame Length Stretcher

This block sits in an Ethernet transmit path between the frame queue and the MAC byte interface. Frame bytes arrive on a valid/ready stream with a last-byte flag and leave on a registered valid/ready stream. On the way the block lengthens short frames in two independent ways. The first is optional zero-valued data padding up to the 64-byte minimum frame. The second is a tail of non-data extension symbols that makes the transmission occupy at least a programmable number of byte times.

Padding is applied first, and the extension target is then compared against the padded length. The extension applies in both half and full duplex, so the block has no duplex input. When padding is off, frames shorter than 32 bytes are swallowed and reported on a one-cycle error pulse. To decide this before any byte is emitted, the first 32 bytes of every frame are held in a small head buffer. The buffer is released as soon as the frame is known to be sendable.

A transmit enable gates only the start of frames. Clearing it lets a frame that has started finish, and the next queued frame waits at the input. The pad-enable bit and the distance value are captured when a frame starts and hold for that whole frame.

Top module: `tx_frame_stretcher`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `m_valid`, `s_ready` and `short_drop` are 0.
- R2: Input data bytes leave unchanged and in order with `m_ext` = 0.
- R3: With `pad_en` = 1, a frame of fewer than 64 bytes is followed by data bytes 0x00 (`m_ext` = 0) until 64 bytes have been sent. Frames of 64 bytes or more gain no padding.
- R4: With `pad_en` = 0, a frame of 1 to 31 bytes is consumed, produces no output beat, and raises `short_drop` for exactly one cycle. A frame of exactly 32 bytes is sent.
- R5: Extension beats carry `m_ext` = 1 and `m_data` = 0x00. They are appended until the total beat count reaches `coll_dist`, and no data beat follows an extension beat within a frame.
- R6: The number of output beats in a frame is max(L, P, `coll_dist`), where L is the input length and P is 64 if padding is on and 0 otherwise. Padding beats come before extension beats.
- R7: `m_last` is 1 on the final beat of each frame and 0 on every other beat.
- R8: While `tx_en` is 0, no new frame is accepted: `s_ready` stays 0 between frames. A frame that has already started completes unchanged.
- R9: `pad_en` and `coll_dist` are sampled when a frame starts. Changing them mid-frame does not alter that frame.
- R10: While `m_valid` = 1 and `m_ready` = 0, `m_valid`, `m_data`, `m_ext` and `m_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Allows new frames to start |
| pad_en | input | 1 | Pad frames with data up to 64 bytes |
| coll_dist | input | 10 | Minimum byte times per transmission |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte ends its frame |
| s_ready | output | 1 | Block accepts the input byte |
| m_valid | output | 1 | Output beat valid |
| m_data | output | 8 | Output byte |
| m_ext | output | 1 | Beat is an extension symbol, not data |
| m_last | output | 1 | Final beat of the frame |
| m_ready | input | 1 | Downstream accepts the beat |
| short_drop | output | 1 | One-cycle pulse for a dropped short frame |

## Verification
The bench targets the edges of the length thresholds. It sends 31- and 32-byte frames with padding off, where an off-by-one design would drop a legal frame or send an illegal one. It sends frames exactly at, just above and below 64 bytes, where a wrong comparison would add or lose a padding byte. It also sends frames whose extension target sits one past the padded length, where a design that compared against the raw length would give the wrong mix of pad and extension beats. Mid-frame changes to the enable and the configuration inputs expose a design that reads them live: it would cut a frame short or change its padding. Output backpressure on a repeating pattern shows whether beats are lost or corrupted while the output is stalled.

// File: rtl/txpx_pkg.sv
package txpx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_PASS,
    ST_PAD,
    ST_EXT
  } txpx_state_e;
endpackage

// File: rtl/txpx_cfg_latch.sv
module txpx_cfg_latch #(
  parameter int CDW     = 10,
  parameter int CW      = 16,
  parameter int PAD_LEN = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  logic           pad_in,
  input  logic [CDW-1:0] dist_in,
  output logic           cfg_pad,
  output logic [CW-1:0]  cfg_need
);
  localparam logic [CW-1:0] PAD_CNT = CW'(PAD_LEN);

  logic [CW-1:0] dist_w;
  logic [CW-1:0] pad_w;
  assign dist_w = CW'(dist_in);
  assign pad_w  = pad_in ? PAD_CNT : '0;

  // The frame end target is the larger of both minimums, fixed at frame start.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pad  <= 1'b0;
      cfg_need <= '0;
    end else if (capture) begin
      cfg_pad  <= pad_in;
      cfg_need <= (dist_w > pad_w) ? dist_w : pad_w;
    end
  end
endmodule

// File: rtl/txpx_head_buf.sv
module txpx_head_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txpx_out_stage.sv
module txpx_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] d_data,
  input  logic          d_ext,
  input  logic          d_last,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          m_ext,
  output logic          m_last,
  output logic          free
);
  assign free = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_ext   <= 1'b0;
      m_last  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= d_data;
      m_ext   <= d_ext;
      m_last  <= d_last;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ext) && $stable(m_last)))
    else $error("output changed while stalled");
endmodule

// File: rtl/tx_frame_stretcher.sv
module tx_frame_stretcher #(
  parameter int DW      = 8,
  parameter int CDW     = 10,
  parameter int PAD_LEN = 64,
  parameter int MIN_LEN = 32,
  parameter int CW      = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_en,
  input  logic           pad_en,
  input  logic [CDW-1:0] coll_dist,
  input  logic           s_valid,
  input  logic [DW-1:0]  s_data,
  input  logic           s_last,
  output logic           s_ready,
  output logic           m_valid,
  output logic [DW-1:0]  m_data,
  output logic           m_ext,
  output logic           m_last,
  input  logic           m_ready,
  output logic           short_drop
);
  import txpx_pkg::*;

  localparam int AW = $clog2(MIN_LEN);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(MIN_LEN);
  localparam logic [CW-1:0] PAD_CNT  = CW'(PAD_LEN);

  txpx_state_e state, nxt;

  logic [AW:0]   wr_cnt, rd_cnt, wr_nxt, rd_nxt;
  logic [CW-1:0] out_cnt, beat_n;
  logic          saw_last, ext_seen;
  logic          capture, we, wr_inc, rd_inc, mark_last, drop, load;
  logic [DW-1:0] d_data, rd_data;
  logic          d_ext, d_last, free;
  logic          cfg_pad;
  logic [CW-1:0] cfg_need;
  logic          done_ok;
  txpx_state_e   tail_state;

  txpx_cfg_latch #(.CDW(CDW), .CW(CW), .PAD_LEN(PAD_LEN)) u_cfg (
    .clk(clk), .rst(rst), .capture(capture), .pad_in(pad_en), .dist_in(coll_dist),
    .cfg_pad(cfg_pad), .cfg_need(cfg_need)
  );

  txpx_head_buf #(.DW(DW), .DEPTH(MIN_LEN), .AW(AW)) u_buf (
    .clk(clk), .we(we), .waddr(wr_cnt[AW-1:0]), .wdata(s_data),
    .raddr(rd_cnt[AW-1:0]), .rdata(rd_data)
  );

  txpx_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .load(load), .d_data(d_data), .d_ext(d_ext), .d_last(d_last),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .m_ext(m_ext),
    .m_last(m_last), .free(free)
  );

  assign wr_nxt  = wr_cnt + 1'b1;
  assign rd_nxt  = rd_cnt + 1'b1;
  assign beat_n  = (out_cnt == '1) ? out_cnt : out_cnt + 1'b1;
  assign done_ok = (beat_n >= cfg_need);

  // Where to go once the beat being emitted now is the last data or pad byte.
  always_comb begin
    if (done_ok)                        tail_state = ST_IDLE;
    else if (cfg_pad && beat_n < PAD_CNT) tail_state = ST_PAD;
    else                                tail_state = ST_EXT;
  end

  always_comb begin
    nxt       = state;
    s_ready   = 1'b0;
    load      = 1'b0;
    d_data    = '0;
    d_ext     = 1'b0;
    d_last    = 1'b0;
    we        = 1'b0;
    capture   = 1'b0;
    drop      = 1'b0;
    wr_inc    = 1'b0;
    rd_inc    = 1'b0;
    mark_last = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (tx_en && s_valid) begin
          capture = 1'b1;
          nxt     = ST_FILL;
        end
      end
      ST_FILL: begin
        s_ready = 1'b1;
        if (s_valid) begin
          we     = 1'b1;
          wr_inc = 1'b1;
          if (s_last) begin
            if (!cfg_pad && wr_nxt < FULL_CNT) begin
              drop = 1'b1;
              nxt  = ST_IDLE;
            end else begin
              mark_last = 1'b1;
              nxt       = ST_DRAIN;
            end
          end else if (wr_nxt == FULL_CNT) begin
            nxt = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (free) begin
          load   = 1'b1;
          rd_inc = 1'b1;
          d_data = rd_data;
          if (rd_nxt == wr_cnt) begin
            d_last = saw_last && done_ok;
            nxt    = saw_last ? tail_state : ST_PASS;
          end
        end
      end
      ST_PASS: begin
        s_ready = free;
        if (s_valid && free) begin
          load   = 1'b1;
          d_data = s_data;
          d_last = s_last && done_ok;
          if (s_last) nxt = tail_state;
        end
      end
      ST_PAD: begin
        if (free) begin
          load   = 1'b1;
          d_last = done_ok;
          nxt    = tail_state;
        end
      end
      ST_EXT: begin
        if (free) begin
          load   = 1'b1;
          d_ext  = 1'b1;
          d_last = done_ok;
          nxt    = done_ok ? ST_IDLE : ST_EXT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_cnt     <= '0;
      rd_cnt     <= '0;
      saw_last   <= 1'b0;
      ext_seen   <= 1'b0;
      out_cnt    <= '0;
      short_drop <= 1'b0;
    end else begin
      state      <= nxt;
      short_drop <= drop;
      if (capture) begin
        wr_cnt   <= '0;
        rd_cnt   <= '0;
        saw_last <= 1'b0;
        ext_seen <= 1'b0;
        out_cnt  <= '0;
      end else begin
        if (wr_inc)    wr_cnt   <= wr_nxt;
        if (rd_inc)    rd_cnt   <= rd_nxt;
        if (mark_last) saw_last <= 1'b1;
        if (load && d_ext) ext_seen <= 1'b1;
        if (load)      out_cnt  <= beat_n;
      end
    end
  end

  assert_gate_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !tx_en) |=> !s_ready)
    else $error("frame accepted while disabled");

  assert_ext_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (ext_seen && load) |-> d_ext)
    else $error("data beat after extension");

  assert_drop_nopad_R4: assert property (@(posedge clk) disable iff (rst)
    short_drop |-> !cfg_pad)
    else $error("drop while padding enabled");

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cfg_need))
    else $error("frame target changed mid-frame");
endmodule

// File: tb/tx_frame_stretcher_test.sv
module tx_frame_stretcher_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, pad_en = 1'b0;
  logic [9:0] coll_dist = '0;
  logic       s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready, m_valid, m_ext, m_last, short_drop;
  logic [7:0] m_data;
  logic       m_ready = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;

  always #4 clk = ~clk;

  tx_frame_stretcher uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .pad_en(pad_en), .coll_dist(coll_dist),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ext(m_ext), .m_last(m_last),
    .m_ready(m_ready), .short_drop(short_drop)
  );

  typedef struct packed {
    int len; int pad; int cd; int total; int drop; int stall;
  } vec_t;

  // len, pad, cd, expected beats, expected drop, output stalls
  localparam vec_t VECS [14] = '{
    '{10, 1, 0, 64, 0, 0},
    '{10, 0, 0, 0, 1, 0},
    '{31, 0, 0, 0, 1, 1},
    '{32, 0, 0, 32, 0, 0},
    '{40, 0, 64, 64, 0, 1},
    '{40, 1, 100, 100, 0, 0},
    '{70, 1, 64, 70, 0, 1},
    '{64, 1, 0, 64, 0, 0},
    '{63, 1, 0, 64, 0, 1},
    '{50, 1, 512, 512, 0, 0},
    '{33, 0, 33, 33, 0, 1},
    '{1, 1, 65, 65, 0, 0},
    '{100, 0, 512, 512, 0, 1},
    '{5, 0, 512, 0, 1, 0}
  };

  function automatic logic [7:0] byte_of(int idx, int len);
    return 8'((idx * 7 + len + 1) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int len, int pad, int cd, int total, int drop,
                           int stall, bit clr_en, bit chg);
    int idx = 0, beats = 0, cyc = 0, tail = 0, padded, ed, ee;
    bit done = 0, drop_seen = 0, held = 0;
    logic [7:0] hd;
    logic he, hl;
    string tag;
    padded = (pad != 0 && len < 64) ? 64 : len;
    @(negedge clk);
    pad_en = pad[0]; coll_dist = cd[9:0]; tx_en = 1'b1;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      s_valid = (idx < len);
      s_data  = byte_of(idx, len);
      s_last  = (idx == len - 1);
      m_ready = (stall != 0) ? (cyc % 3 != 2) : 1'b1;
      if (chg && idx == 3) begin pad_en = ~pad[0]; coll_dist = '0; end
      if (clr_en && idx == 2) tx_en = 1'b0;
      #1;
      if (held) begin
        check(m_valid && m_data == hd && m_ext == he && m_last == hl, "R10",
              {m_valid, m_ext, m_last, m_data}, {1'b1, he, hl, hd}, "stalled beat changed");
        held = 0;
      end
      if (short_drop) drop_seen = 1;
      if (s_valid && s_ready) idx++;
      if (m_valid && m_ready) begin
        if (beats < len) begin ed = byte_of(beats, len); ee = 0; tag = "R2"; end
        else if (beats < padded) begin ed = 0; ee = 0; tag = "R3"; end
        else begin ed = 0; ee = 1; tag = "R5"; end
        check(m_data == 8'(ed) && m_ext == ee[0], tag, {m_ext, m_data}, (ee << 8) | ed,
              $sformatf("beat %0d {ext,data}", beats));
        check(m_last == (beats == total - 1), "R7", m_last, beats == total - 1,
              $sformatf("last flag beat %0d", beats));
        beats++;
        if (m_last) done = 1;
      end else if (m_valid) begin
        held = 1; hd = m_data; he = m_ext; hl = m_last;
      end
      if (drop != 0 && idx == len) begin
        tail++;
        if (tail > 6) done = 1;
      end
      cyc++;
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    tag = (drop != 0) ? "R4" : (chg ? "R9" : (clr_en ? "R8" : "R6"));
    check(beats == total, tag, beats, total, "beat count");
    check(drop_seen == drop[0], "R4", drop_seen, drop, "short_drop pulse");
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    check(!m_valid && !s_ready && !short_drop, "R1", {m_valid, s_ready, short_drop}, 0, "in reset");
    rst = 1'b0;
    @(negedge clk);
    check(!m_valid && !s_ready && !short_drop, "R1", {m_valid, s_ready, short_drop}, 0, "after reset");

    foreach (VECS[i])
      run_frame(VECS[i].len, VECS[i].pad, VECS[i].cd, VECS[i].total,
                VECS[i].drop, VECS[i].stall, 1'b0, 1'b0);

    // R9 config changed during the frame: expected as originally set
    run_frame(20, 1, 70, 70, 0, 0, 1'b0, 1'b1);

    // R8 enable cleared mid-frame: frame completes
    run_frame(45, 0, 0, 45, 0, 1, 1'b1, 1'b0);

    // R8 no new frame while disabled
    @(negedge clk);
    tx_en = 1'b0; s_valid = 1'b1; s_data = 8'h5A; s_last = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      #1;
      check(!s_ready && !m_valid, "R8", {s_ready, m_valid}, 0, "idle while disabled");
    end
    s_valid = 1'b0;

    // queued frame goes once re-enabled
    run_frame(36, 0, 40, 40, 0, 0, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule